// File: doc/BRIEF.md
# Locked Stepped-Sine Excitation and Sample Timer

This block produces the excitation for a bridge or sensor as a 4-bit code that an external resistor ladder turns into a stepped sine wave. A single divider on the system clock sets the step rate: every step period the block advances one position in a sixteen-entry sine table, so one waveform cycle spans sixteen step periods. With the default divider of 100 on a 40 MHz clock, the code changes every 2.5 µs and the waveform repeats at 25 kHz.

The same divider also times the converter trigger, so sampling can never drift against the excitation. The trigger fires once per step period, at a programmable count inside that period, which sets the phase of sampling against the waveform. Sampling runs in batches: a restart request arms a new batch at the next return of the waveform to its first entry, so every batch begins at the same point of the wave. A one-clock cycle-start pulse marks each such return and can restart phase counters further down the chain.

Top module: `sine_ref_gen`

## Requirements
- R1: After reset the code is 8 (mid-scale, table entry 0). The table entries 0 to 15 hold 8, 11, 13, 14, 15, 14, 13, 11, 8, 5, 3, 2, 1, 2, 3, 5 (that is, 8 plus 7·sin(2πk/16), rounded), and after entry 15 the sequence goes back to entry 0.
- R2: The code holds for exactly DIV clocks (default 100) and changes on each clock whose count since the internal reset release is a multiple of DIV.
- R3: cycle_start is high for exactly one clock, in the first clock where the code is back at entry 0 after entry 15; it stays low from reset until the first wrap.
- R4: After reset no batch is active: adc_trig and batch_busy are low until a restart request has taken effect.
- R5: A restart request (resync_req high for one clock) takes effect at the next waveform wrap, never mid-cycle: batch_busy rises in the same clock that cycle_start is high.
- R6: While a batch is active, adc_trig pulses for one clock once per step period; with phase offset P, the first pulse appears P+1 clocks after cycle_start and the next ones follow every DIV clocks.
- R7: A batch holds BATCH_LEN triggers (default 32); batch_busy drops in the same clock as the last trigger pulse, and no further pulses appear until a new restart.
- R8: A phase_load with phase_val below DIV stores the offset, and it becomes active only at the next waveform wrap.
- R9: A phase_load with phase_val of DIV or more is ignored: the previous offset stays in use.
- R10: A restart request during an active batch restarts the trigger count at the next wrap, so the batch extends to BATCH_LEN triggers counted from that wrap and batch_busy does not drop in between.
- R11: The largest offset, DIV-1, is supported: triggers fall on the last clock of each step period and a full batch is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside the block on the clock |
| phase_load | input | 1 | Stores phase_val as the pending sample offset |
| phase_val | input | PHASE_W (8) | Sample offset in clocks within a step period |
| resync_req | input | 1 | Requests a new sampling batch aligned to the waveform start |
| ref_code | output | 4 | Ladder code for the stepped sine |
| cycle_start | output | 1 | One-clock pulse when the waveform returns to entry 0 |
| adc_trig | output | 1 | One-clock converter trigger pulse |
| batch_busy | output | 1 | High while a sampling batch is in progress |

## Verification
A wrong step counter shows up as a code that changes one clock early or late, visible within one step period of the fault; a wrong table index shows as a wrong code value or a misplaced cycle_start within one waveform cycle. Errors in the sample side show as trigger pulses shifted from the expected offset, present outside a batch, or a batch that ends with the wrong number of pulses, all visible within one step period of the divergence. Every output is compared on every clock against values computed from the clock count, the offset and the restart times, so a single misplaced pulse is caught where it happens.

// File: rtl/sref_pkg.sv
package sref_pkg;

  localparam int unsigned CODE_W  = 4;
  localparam int unsigned TBL_LEN = 16;
  localparam int unsigned IDX_W   = 4;
  localparam logic [CODE_W-1:0] MID_CODE = 4'd8;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [CODE_W-1:0] code_t;

  // Quarter-wave amplitude for offsets 0..4 from the zero crossing.
  function automatic logic [2:0] quarter_amp(input logic [2:0] m);
    logic [2:0] a;
    case (m)
      3'd0:    a = 3'd0;
      3'd1:    a = 3'd3;
      3'd2:    a = 3'd5;
      3'd3:    a = 3'd6;
      default: a = 3'd7;
    endcase
    return a;
  endfunction

  // Stepped sine code: mid-scale plus or minus the mirrored quarter amplitude.
  function automatic code_t sine_code(input idx_t k);
    logic [2:0] q;
    logic [2:0] m;
    logic [2:0] amp;
    q   = k[2:0];
    m   = (q <= 3'd4) ? q : 3'(4'd8 - {1'b0, q});
    amp = quarter_amp(m);
    return k[3] ? code_t'(MID_CODE - {1'b0, amp}) : code_t'(MID_CODE + {1'b0, amp});
  endfunction

endpackage

// File: rtl/sref_timebase.sv
module sref_timebase #(
  parameter int unsigned DIV = 100,
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             tick_c;

  assign tick_c = (cnt_q == CNT_W'(DIV - 1));

  always_comb begin
    cnt_n = cnt_q + CNT_W'(1);
    if (tick_c) cnt_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_c;

  // R2: the divider never leaves its range
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < DIV);

  // R2: a step tick restarts the count
  p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_o == '0));

endmodule

// File: rtl/sref_wave.sv
module sref_wave
  import sref_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  output code_t code_o,
  output logic  wrap_o,
  output logic  cycle_start_o
);

  idx_t  idx_q, idx_n;
  code_t code_q, code_n;
  logic  cs_q, cs_n;
  logic  wrap_c;

  assign wrap_c = tick_i && (idx_q == IDX_W'(TBL_LEN - 1));

  always_comb begin
    idx_n  = idx_q;
    code_n = code_q;
    cs_n   = 1'b0;
    if (tick_i) begin
      idx_n  = idx_q + IDX_W'(1);
      code_n = sine_code(idx_q + IDX_W'(1));
      cs_n   = wrap_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      code_q <= MID_CODE;
      cs_q   <= 1'b0;
    end else begin
      idx_q  <= idx_n;
      code_q <= code_n;
      cs_q   <= cs_n;
    end
  end

  assign code_o        = code_q;
  assign wrap_o        = wrap_c;
  assign cycle_start_o = cs_q;

  // R3: the start pulse only marks entry 0 at mid-scale
  p_cs_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start_o |-> (idx_q == '0 && code_o == MID_CODE));

  // R3: the start pulse lasts one clock
  p_cs_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start_o |=> !cycle_start_o);

  // R2: the index only moves on a step tick
  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(idx_q));

endmodule

// File: rtl/sref_sampler.sv
module sref_sampler #(
  parameter int unsigned DIV       = 100,
  parameter int unsigned PHASE_W   = 8,
  parameter int unsigned BATCH_LEN = 32,
  localparam int unsigned CNT_W  = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int unsigned BCNT_W = (BATCH_LEN > 1) ? $clog2(BATCH_LEN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               wrap_i,
  input  logic               phase_load_i,
  input  logic [PHASE_W-1:0] phase_val_i,
  input  logic               resync_i,
  output logic               adc_trig_o,
  output logic               busy_o
);

  logic [CNT_W-1:0]  ph_act_q, ph_act_n;
  logic [CNT_W-1:0]  ph_pend_q, ph_pend_n;
  logic              ph_pv_q, ph_pv_n;
  logic              rs_pend_q, rs_pend_n;
  logic              armed_q, armed_n;
  logic [BCNT_W-1:0] bcnt_q, bcnt_n;
  logic              trig_q;
  logic              trig_c;
  logic              load_ok;

  assign trig_c  = armed_q && (cnt_i == ph_act_q);
  assign load_ok = phase_load_i && (int'(phase_val_i) < DIV);

  always_comb begin
    ph_act_n  = ph_act_q;
    ph_pend_n = ph_pend_q;
    ph_pv_n   = ph_pv_q;
    rs_pend_n = rs_pend_q;
    armed_n   = armed_q;
    bcnt_n    = bcnt_q;
    // count triggers of the running batch
    if (trig_c) begin
      if (bcnt_q == BCNT_W'(BATCH_LEN - 1)) armed_n = 1'b0;
      else                                  bcnt_n  = bcnt_q + BCNT_W'(1);
    end
    // pending changes are applied only at a waveform wrap
    if (wrap_i) begin
      if (ph_pv_q) begin
        ph_act_n = ph_pend_q;
        ph_pv_n  = 1'b0;
      end
      if (rs_pend_q) begin
        armed_n   = 1'b1;
        bcnt_n    = '0;
        rs_pend_n = 1'b0;
      end
    end
    // new requests are captured last so none is lost at a wrap
    if (load_ok) begin
      ph_pend_n = CNT_W'(phase_val_i);
      ph_pv_n   = 1'b1;
    end
    if (resync_i) rs_pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_act_q  <= '0;
      ph_pend_q <= '0;
      ph_pv_q   <= 1'b0;
      rs_pend_q <= 1'b0;
      armed_q   <= 1'b0;
      bcnt_q    <= '0;
      trig_q    <= 1'b0;
    end else begin
      ph_act_q  <= ph_act_n;
      ph_pend_q <= ph_pend_n;
      ph_pv_q   <= ph_pv_n;
      rs_pend_q <= rs_pend_n;
      armed_q   <= armed_n;
      bcnt_q    <= bcnt_n;
      trig_q    <= trig_c;
    end
  end

  assign adc_trig_o = trig_q;
  assign busy_o     = armed_q;

  // R6: a trigger only follows a clock with an armed batch
  p_trig_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig_o |-> $past(armed_q));

  // R5: a batch only starts right after a waveform wrap
  p_arm_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(wrap_i));

  // R8: the active offset never changes mid-cycle
  p_phase_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(ph_act_q));

  // R9: the active offset always lies inside a step period
  p_phase_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ph_act_q) < DIV);

  // R7: the last trigger of a batch ends it unless a restart coincides
  p_batch_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_c && bcnt_q == BCNT_W'(BATCH_LEN - 1) && !wrap_i) |=> !busy_o);

endmodule

// File: rtl/sine_ref_gen.sv
module sine_ref_gen #(
  parameter int unsigned DIV       = 100,
  parameter int unsigned PHASE_W   = 8,
  parameter int unsigned BATCH_LEN = 32,
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase_load,
  input  logic [PHASE_W-1:0] phase_val,
  input  logic               resync_req,
  output logic [3:0]         ref_code,
  output logic               cycle_start,
  output logic               adc_trig,
  output logic               batch_busy
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] tb_cnt;
  logic             tb_tick;
  logic             wv_wrap;

  // asynchronous assertion, clocked release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sref_timebase #(.DIV(DIV)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cnt_o  (tb_cnt),
    .tick_o (tb_tick)
  );

  sref_wave u_wave (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .tick_i        (tb_tick),
    .code_o        (ref_code),
    .wrap_o        (wv_wrap),
    .cycle_start_o (cycle_start)
  );

  sref_sampler #(
    .DIV       (DIV),
    .PHASE_W   (PHASE_W),
    .BATCH_LEN (BATCH_LEN)
  ) u_sampler (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cnt_i        (tb_cnt),
    .wrap_i       (wv_wrap),
    .phase_load_i (phase_load),
    .phase_val_i  (phase_val),
    .resync_i     (resync_req),
    .adc_trig_o   (adc_trig),
    .busy_o       (batch_busy)
  );

endmodule

// File: tb/test_sine_ref_gen.sv
module test_sine_ref_gen;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 100;
  localparam int LEN        = 16;
  localparam int BATCH      = 32;
  localparam int CYC        = DIV * LEN;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       phase_load;
  logic [7:0] phase_val;
  logic       resync_req;
  logic [3:0] ref_code;
  logic       cycle_start;
  logic       adc_trig;
  logic       batch_busy;

  int  checks = 0;
  int  errors = 0;
  int  e_cnt  = 0;
  bit  mon_en = 1'b0;
  bit  done   = 1'b0;

  // expected-state bookkeeping, in clock counts since internal reset release
  int w_cur   = -1;
  int w_pend  = -1;
  int ph_cur  = 0;
  int ph_pend = 0;
  int ph_at   = -1;

  sine_ref_gen i_sine_ref_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_load  (phase_load),
    .phase_val   (phase_val),
    .resync_req  (resync_req),
    .ref_code    (ref_code),
    .cycle_start (cycle_start),
    .adc_trig    (adc_trig),
    .batch_busy  (batch_busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) if (rst_n) e_cnt = e_cnt + 1;

  function automatic int now_e();
    return (e_cnt > 2) ? e_cnt - 2 : 0;
  endfunction

  function automatic int exp_code(int k);
    real r;
    r = 8.0 + 7.0 * $sin(2.0 * 3.14159265358979 * k / 16.0);
    return int'(r);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at clock %0d: actual %0d expected %0d", req, now_e(), act, exp);
    end
  endtask

  // per-clock comparison of every output
  always @(negedge clk) begin
    if (mon_en && !done) begin
      int e;
      int xc, xs, xa, xb;
      e = now_e();
      if (ph_at >= 0 && e >= ph_at) begin ph_cur = ph_pend; ph_at = -1; end
      if (w_pend >= 0 && e >= w_pend) begin w_cur = w_pend; w_pend = -1; end
      xc = exp_code((e / DIV) % LEN);
      xs = (e > 0 && e % CYC == 0) ? 1 : 0;
      xa = (w_cur >= 0 && e - 1 >= w_cur && (e - 1 - w_cur) % DIV == ph_cur &&
            (e - 1 - w_cur - ph_cur) / DIV < BATCH) ? 1 : 0;
      xb = (w_cur >= 0 && e >= w_cur && e <= w_cur + ph_cur + (BATCH - 1) * DIV) ? 1 : 0;
      chk(int'(ref_code) == xc, "R1 R2 code", int'(ref_code), xc);
      chk(int'(cycle_start) == xs, "R3 cycle_start", int'(cycle_start), xs);
      chk(int'(adc_trig) == xa, "R6 adc_trig", int'(adc_trig), xa);
      chk(int'(batch_busy) == xb, "R7 batch_busy", int'(batch_busy), xb);
    end
  end

  task automatic goto(input int t);
    while (now_e() < t) @(negedge clk);
  endtask

  // offset load plus restart request in one clock; returns the start wrap
  task automatic start_batch(input int val, input bit do_load, output int w);
    int s;
    s = now_e() + 1;
    w = (s / CYC + 1) * CYC;
    phase_load = do_load;
    phase_val  = 8'(val);
    resync_req = 1'b1;
    if (do_load && val < DIV) begin ph_pend = val; ph_at = w; end
    w_pend = w;
    @(negedge clk);
    phase_load = 1'b0;
    resync_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w1, w2, w3, w4, w5;
    rst_n      = 1'b0;
    phase_load = 1'b0;
    phase_val  = '0;
    resync_req = 1'b0;
    repeat (5) @(negedge clk);
    mon_en = 1'b1;
    chk(ref_code == 4'd8, "R1 reset code", int'(ref_code), 8);
    rst_n = 1'b1;

    goto(5);
    chk(!adc_trig && !batch_busy, "R4 idle after reset", int'({adc_trig, batch_busy}), 0);
    goto(1000);

    // offset 37, fresh batch
    start_batch(37, 1'b1, w1);
    goto(w1 - 1);
    chk(!batch_busy, "R5 no start before wrap", int'(batch_busy), 0);
    goto(w1);
    chk(cycle_start && batch_busy, "R5 start at wrap", int'({cycle_start, batch_busy}), 3);
    goto(w1 + 37);
    chk(!adc_trig, "R8 not before offset", int'(adc_trig), 0);
    goto(w1 + 38);
    chk(adc_trig, "R8 first trigger at offset", int'(adc_trig), 1);
    goto(w1 + 37 + 31 * DIV + 1);
    chk(adc_trig && !batch_busy, "R7 last trigger ends batch", int'({adc_trig, batch_busy}), 2);
    goto(w1 + 37 + 32 * DIV + 1);
    chk(!adc_trig, "R7 no trigger after batch", int'(adc_trig), 0);

    // out-of-range offset is ignored
    goto(w1 + 4000);
    start_batch(150, 1'b1, w2);
    goto(w2 + 38);
    chk(adc_trig, "R9 old offset kept", int'(adc_trig), 1);

    // largest offset
    goto(w2 + 3300);
    start_batch(99, 1'b1, w3);
    goto(w3 + 100);
    chk(adc_trig, "R11 first trigger at last clock", int'(adc_trig), 1);
    goto(w3 + 99 + 31 * DIV + 1);
    chk(adc_trig && !batch_busy, "R11 full batch", int'({adc_trig, batch_busy}), 2);

    // restart during a running batch
    goto(w3 + 3300);
    start_batch(0, 1'b1, w4);
    goto(w4 + 500);
    start_batch(0, 1'b0, w5);
    chk(w5 == w4 + CYC, "R10 restart wrap", w5, w4 + CYC);
    goto(w4 + 31 * DIV + 1);
    chk(adc_trig && batch_busy, "R10 batch extended", int'({adc_trig, batch_busy}), 3);
    goto(w5 + 31 * DIV + 1);
    chk(adc_trig && !batch_busy, "R10 extended batch ends", int'({adc_trig, batch_busy}), 2);
    goto(w5 + 3500);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule